// File: doc/BRIEF.md
# Split Instruction/Data Address Translation Unit

This block turns a virtual address into a physical address for a processor core. It holds two small direct-mapped lookup tables: one serves instruction fetches and the other serves loads and stores. Each slot holds two words. The tag word carries the virtual page and a valid flag. The frame word carries the physical page and the access rights. The rights are checked against the current privilege level. A failure is reported either as a table miss or as a page fault, and the faulting virtual address is kept in a register for the trap handler.

A request is one cycle of `req_valid` carrying an address, an access kind and the privilege level. The result appears, registered, in the next cycle. Software-managed refills go through a synchronous write port. That port picks the table, the slot and which of the two words to replace. In supervisor mode, a small window at the bottom of the address space is passed through untranslated, so trap handlers can run before any slot is loaded.

Top module: `tlbx_xlate`

## Requirements
- R1: After reset every slot of both tables is invalid, `rsp_valid` is low and `fault_vaddr` is zero. Any translated lookup then misses.
- R2: A request with `req_valid` high produces `rsp_valid` high in exactly the next cycle. Without a request, `rsp_valid`, `rsp_hit`, `rsp_perm`, `rsp_exc` and `rsp_paddr` are all zero in the next cycle.
- R3: The slot index is `vaddr[18:13]`. A lookup hits only when the slot's stored tag bits [31:13] equal all of `vaddr[31:13]` and the tag word's bit 0 (valid) is set. Otherwise it is a miss.
- R4: `wr_sel_data` 0 selects the instruction table and 1 selects the data table. `wr_word_tr` 0 writes the tag word and 1 writes the frame word. A write affects requests from the following cycle on. A request in the same cycle sees the old contents.
- R5: On a translated hit, `rsp_paddr` is frame word bits [31:13] followed by `vaddr[12:0]`.
- R6: Access codes: `req_acc` 2'b10 is a fetch, 2'b00 is a load, 2'b01 is a store, and 2'b11 behaves as a load. A fetch has execute right from frame bit 7 in supervisor mode and from bit 6 in user mode. A fetch without that right is an instruction page fault.
- R7: For data, read right comes from frame bit 8 (supervisor) or bit 6 (user), and write right comes from bit 9 (supervisor) or bit 7 (user). A store without write right, or a load without read right, is a data page fault.
- R8: In supervisor mode, an address below 0x2000 is not looked up. It hits with `rsp_paddr` equal to the address and `rsp_perm` 3'b011. In user mode the same address is translated normally.
- R9: `rsp_exc` codes: 0 none, 1 instruction miss, 2 data miss, 3 instruction page fault, 4 data page fault. A miss takes precedence over a rights check. `rsp_hit` is high exactly when the code is 0.
- R10: `fault_vaddr` takes the virtual address of every faulting request, visible together with its response. At all other times it holds its value.
- R11: `rsp_perm` bit 0 is read, bit 1 is write and bit 2 is execute. A fetch hit reports only bit 2, and a data hit reports only bits 0 and 1. On a fault both `rsp_perm` and `rsp_paddr` are zero.
- R12: The two tables are independent. A slot loaded in one table never makes an access of the other kind hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind (10 fetch, 00 load, 01 store, 11 load) |
| req_super | input | 1 | Request issued in supervisor mode |
| wr_en | input | 1 | Table write strobe |
| wr_sel_data | input | 1 | 0 instruction table, 1 data table |
| wr_idx | input | 6 | Slot to write |
| wr_word_tr | input | 1 | 0 tag word, 1 frame word |
| wr_value | input | 32 | Word to store |
| rsp_valid | output | 1 | Result of last cycle's request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted rights {exec, write, read} |
| rsp_exc | output | 3 | Exception code |
| fault_vaddr | output | 32 | Virtual address of the last fault |

## Verification
On every cycle the assertions check the one-cycle response timing and the silence without a request. They also check that the hit flag agrees with the exception code, that the page offset passes through, the bypass window, which rights each access kind may report, and the capture and hold of the fault address. The actual slot contents only show up in the bench's scenarios: tag aliasing on a shared index, invalidation, a write racing a read, the per-mode selection of individual rights bits, and the separation of the two tables. There, a behavioural model of both tables predicts every output on every clock.

// File: rtl/tlbx_pkg.sv
// Shared encodings for the translation unit: access kinds, exception codes
// and the position of the rights field inside a frame word.
package tlbx_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_LOAD2 = 2'b11
    } acc_e;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_IMISS = 3'd1,
        EXC_DMISS = 3'd2,
        EXC_IPF   = 3'd3,
        EXC_DPF   = 3'd4
    } exc_e;

    // lowest bit of the rights field in a frame word
    localparam int RIGHT_LSB = 6;
    // number of rights bits kept per slot
    localparam int RIGHTS_W  = 4;

endpackage

// File: rtl/tlbx_way.sv
// One direct-mapped table of translation slots.
// Holds a valid flag, a virtual page tag, a physical frame and a rights
// field per slot. Lookup is combinational on the virtual page number; the
// low IDX_W bits of the page number pick the slot. Only the valid flags are
// reset; tag/frame/rights are don't-care while their slot is invalid.
// Assumes the caller registers the lookup result.
module tlbx_way #(
    parameter int ADDR_W    = 32,
    parameter int PG_BITS   = 13,
    parameter int IDX_W     = 6,
    parameter int RIGHTS_W  = 4,
    parameter int RIGHT_LSB = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_word_tr,
    input  logic [ADDR_W-1:0]           wr_value,
    input  logic [ADDR_W-PG_BITS-1:0]   rd_vpn,
    output logic                        rd_hit,
    output logic [ADDR_W-PG_BITS-1:0]   rd_ppn,
    output logic [RIGHTS_W-1:0]         rd_rights
);
    localparam int VPN_W   = ADDR_W - PG_BITS;
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]    tag_q   [ENTRIES];
    logic [VPN_W-1:0]    ppn_q   [ENTRIES];
    logic [RIGHTS_W-1:0] rgt_q   [ENTRIES];
    logic [IDX_W-1:0]    rd_idx;
    logic                unused_wr_bits;

    // bits of the written word outside tag/frame/rights/valid are ignored
    assign unused_wr_bits = ^wr_value;

    // valid flags: cleared by reset, rewritten with every tag-word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en && !wr_word_tr) begin
            vld_q[wr_idx] <= wr_value[0];
        end
    end

    // slot payload: tag on tag-word writes, frame and rights on frame-word writes
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (!wr_word_tr) begin
                tag_q[wr_idx] <= wr_value[ADDR_W-1:PG_BITS];
            end else begin
                ppn_q[wr_idx] <= wr_value[ADDR_W-1:PG_BITS];
                rgt_q[wr_idx] <= wr_value[RIGHT_LSB +: RIGHTS_W];
            end
        end
    end

    // lookup: full-page tag compare qualified by the valid flag
    always_comb begin
        rd_idx    = rd_vpn[IDX_W-1:0];
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_vpn);
        rd_ppn    = ppn_q[rd_idx];
        rd_rights = rgt_q[rd_idx];
    end

endmodule

// File: rtl/tlbx_rights.sv
// Classifies one lookup: bypass, miss, rights failure or success.
// Rights field layout (relative to the field's lsb):
//   fetch: [0] user execute, [1] supervisor execute
//   data : [0] user read, [1] user write, [2] supervisor read, [3] supervisor write
// A miss wins over a rights failure. Purely combinational.
module tlbx_rights
    import tlbx_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic          is_fetch,
    input  logic          is_store,
    input  logic          in_super,
    input  logic          bypass,
    input  logic          hit,
    input  logic [RW-1:0] rights,
    output logic [2:0]    exc_code,
    output logic [2:0]    perm
);
    logic can_x;
    logic can_r;
    logic can_w;

    // pick the rights that apply to the current privilege level
    always_comb begin
        can_x = in_super ? rights[1] : rights[0];
        can_r = in_super ? rights[2] : rights[0];
        can_w = in_super ? rights[3] : rights[1];
    end

    // decide the outcome and the rights reported on success
    always_comb begin
        exc_code = EXC_NONE;
        perm     = 3'b000;
        if (bypass) begin
            perm = 3'b011;
        end else if (!hit) begin
            exc_code = is_fetch ? EXC_IMISS : EXC_DMISS;
        end else if (is_fetch) begin
            if (can_x) perm = 3'b100;
            else       exc_code = EXC_IPF;
        end else begin
            if (is_store ? can_w : can_r) perm = {1'b0, can_w, can_r};
            else                          exc_code = EXC_DPF;
        end
    end

endmodule

// File: rtl/tlbx_xlate.sv
// Top of the translation unit.
// Two tlbx_way tables (0: instruction, 1: data) share one write port and one
// request port. A request is classified by tlbx_rights and the outcome is
// registered, so results appear one cycle after req_valid. The virtual
// address of every faulting request is captured in fault_vaddr.
// Assumes at most one request per cycle and no back-pressure.
module tlbx_xlate
    import tlbx_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PG_BITS      = 13,
    parameter int IDX_W        = 6,
    parameter int BYPASS_LIMIT = 32'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_super,
    input  logic              wr_en,
    input  logic              wr_sel_data,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_word_tr,
    input  logic [ADDR_W-1:0] wr_value,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic [2:0]        rsp_exc,
    output logic [ADDR_W-1:0] fault_vaddr
);
    localparam int VPN_W = ADDR_W - PG_BITS;
    localparam int WAYS  = 2;
    localparam logic [ADDR_W-1:0] BYP_LIM = ADDR_W'(BYPASS_LIMIT);

    logic                way_hit [WAYS];
    logic [VPN_W-1:0]    way_ppn [WAYS];
    logic [RIGHTS_W-1:0] way_rgt [WAYS];

    logic              is_fetch;
    logic              is_store;
    logic              bypass;
    logic              sel_data;
    logic [2:0]        nxt_exc;
    logic [2:0]        nxt_perm;
    logic [ADDR_W-1:0] nxt_paddr;

    // one table per access class, each written only when selected
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        tlbx_way #(
            .ADDR_W    (ADDR_W),
            .PG_BITS   (PG_BITS),
            .IDX_W     (IDX_W),
            .RIGHTS_W  (RIGHTS_W),
            .RIGHT_LSB (RIGHT_LSB)
        ) i_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en && (wr_sel_data == 1'(g))),
            .wr_idx     (wr_idx),
            .wr_word_tr (wr_word_tr),
            .wr_value   (wr_value),
            .rd_vpn     (req_vaddr[ADDR_W-1:PG_BITS]),
            .rd_hit     (way_hit[g]),
            .rd_ppn     (way_ppn[g]),
            .rd_rights  (way_rgt[g])
        );
    end

    // decode the access kind and the supervisor pass-through window
    always_comb begin
        is_fetch = (req_acc == ACC_FETCH);
        is_store = (req_acc == ACC_STORE);
        sel_data = !is_fetch;
        bypass   = req_super && (req_vaddr < BYP_LIM);
    end

    tlbx_rights #(
        .RW (RIGHTS_W)
    ) i_rights (
        .is_fetch (is_fetch),
        .is_store (is_store),
        .in_super (req_super),
        .bypass   (bypass),
        .hit      (way_hit[sel_data]),
        .rights   (way_rgt[sel_data]),
        .exc_code (nxt_exc),
        .perm     (nxt_perm)
    );

    // form the physical address; zero whenever the request faults
    always_comb begin
        if (nxt_exc != EXC_NONE) begin
            nxt_paddr = '0;
        end else if (bypass) begin
            nxt_paddr = req_vaddr;
        end else begin
            nxt_paddr = {way_ppn[sel_data], req_vaddr[PG_BITS-1:0]};
        end
    end

    // register the outcome; idle cycles return all-zero results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
            rsp_exc   <= EXC_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit   <= (nxt_exc == EXC_NONE);
                rsp_paddr <= nxt_paddr;
                rsp_perm  <= nxt_perm;
                rsp_exc   <= nxt_exc;
            end else begin
                rsp_hit   <= 1'b0;
                rsp_paddr <= '0;
                rsp_perm  <= '0;
                rsp_exc   <= EXC_NONE;
            end
        end
    end

    // capture the virtual address of each faulting request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_vaddr <= '0;
        end else if (req_valid && (nxt_exc != EXC_NONE)) begin
            fault_vaddr <= req_vaddr;
        end
    end

endmodule

// File: rtl/tlbx_xlate_chk.sv
// Protocol checker for tlbx_xlate, attached with bind below.
// Relates request inputs to the registered outputs one cycle later.
module tlbx_xlate_chk
    import tlbx_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PG_BITS      = 13,
    parameter int BYPASS_LIMIT = 32'h2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic [1:0]        req_acc,
    input logic              req_super,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [2:0]        rsp_perm,
    input logic [2:0]        rsp_exc,
    input logic [ADDR_W-1:0] fault_vaddr
);
    localparam logic [ADDR_W-1:0] LIM = ADDR_W'(BYPASS_LIMIT);

    // R2: a request is answered in the next cycle
    a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("a_r2_answer_next");

    // R2: no request, quiet response
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && rsp_exc == EXC_NONE))
        else $error("a_r2_quiet_idle");

    // R9: hit flag agrees with the exception code
    a_r9_hit_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit == (rsp_exc == EXC_NONE)))
        else $error("a_r9_hit_code");

    // R5: page offset passes through on every hit
    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_paddr[PG_BITS-1:0] == $past(req_vaddr[PG_BITS-1:0])))
        else $error("a_r5_offset_kept");

    // R8: supervisor low window is identity-mapped read/write
    a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_super && req_vaddr < LIM) |=>
            (rsp_hit && rsp_paddr == $past(req_vaddr) && rsp_perm == 3'b011))
        else $error("a_r8_bypass");

    // R6: fetches only report instruction-side codes
    a_r6_fetch_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == ACC_FETCH) |=>
            (rsp_exc == EXC_NONE || rsp_exc == EXC_IMISS || rsp_exc == EXC_IPF))
        else $error("a_r6_fetch_codes");

    // R11: rights reported match the access class, none on a fault
    a_r11_fetch_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == ACC_FETCH && !(req_super && req_vaddr < LIM)) |=>
            (rsp_perm[1:0] == 2'b00))
        else $error("a_r11_fetch_perm");

    a_r11_fault_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_perm == 3'b000 && rsp_paddr == '0))
        else $error("a_r11_fault_perm");

    // R10: fault address captured with the faulting response
    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (fault_vaddr == $past(req_vaddr)))
        else $error("a_r10_capture");

    // R10: fault address holds otherwise
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && !rsp_hit) |-> $stable(fault_vaddr))
        else $error("a_r10_hold");

endmodule

bind tlbx_xlate tlbx_xlate_chk #(
    .ADDR_W       (ADDR_W),
    .PG_BITS      (PG_BITS),
    .BYPASS_LIMIT (BYPASS_LIMIT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .req_acc     (req_acc),
    .req_super   (req_super),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_paddr   (rsp_paddr),
    .rsp_perm    (rsp_perm),
    .rsp_exc     (rsp_exc),
    .fault_vaddr (fault_vaddr)
);

// File: tb/test_tlbx_xlate.sv
`timescale 1ns/1ps
// Bench for tlbx_xlate: a behavioural model of both tables predicts every
// output; predictions are compared at each falling edge.
module test_tlbx_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = 2'b00;
    logic        req_super = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel_data = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_word_tr = 1'b0;
    logic [31:0] wr_value = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [2:0]  rsp_exc;
    logic [31:0] fault_vaddr;

    always #4 clk = ~clk;

    tlbx_xlate i_tlbx_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_super(req_super),
        .wr_en(wr_en), .wr_sel_data(wr_sel_data), .wr_idx(wr_idx), .wr_word_tr(wr_word_tr),
        .wr_value(wr_value),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_perm(rsp_perm), .rsp_exc(rsp_exc), .fault_vaddr(fault_vaddr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: [table][slot][word], word 0 tag, word 1 frame
    logic [31:0] mdl [0:1][0:63][0:1];

    // pending predictions for the outputs after the next edge
    bit          e_valid = 0;
    bit          e_hit = 0;
    logic [31:0] e_paddr = '0;
    logic [2:0]  e_perm = '0;
    logic [2:0]  e_exc = '0;
    logic [31:0] e_fault = '0;
    string       e_tag = "R1";

    localparam logic [1:0] LD = 2'b00, ST = 2'b01, FE = 2'b10, LD2 = 2'b11;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(rsp_valid === e_valid, e_tag, "valid", 32'(rsp_valid), 32'(e_valid));
        chk(rsp_hit === e_hit, e_tag, "hit", 32'(rsp_hit), 32'(e_hit));
        chk(rsp_exc === e_exc, e_tag, "exc", 32'(rsp_exc), 32'(e_exc));
        chk(rsp_perm === e_perm, e_tag, "perm", 32'(rsp_perm), 32'(e_perm));
        chk(rsp_paddr === e_paddr, e_tag, "paddr", rsp_paddr, e_paddr);
        chk(fault_vaddr === e_fault, e_tag, "fault_vaddr", fault_vaddr, e_fault);
    endtask

    // behavioural prediction from the requirements
    task automatic predict(input bit rv, input logic [31:0] va, input logic [1:0] acc,
                           input bit sup);
        int          tb;
        int          slot;
        logic [31:0] tw;
        logic [31:0] fw;
        bit          ok;
        bit          x, r, w;
        e_valid = rv; e_hit = 0; e_paddr = '0; e_perm = '0; e_exc = 3'd0;
        if (!rv) return;
        tb   = (acc == FE) ? 0 : 1;
        slot = int'((va / 32'd8192) % 32'd64);
        tw   = mdl[tb][slot][0];
        fw   = mdl[tb][slot][1];
        if (sup && va < 32'h2000) begin
            e_hit = 1; e_paddr = va; e_perm = 3'b011;
            return;
        end
        if (tw[0] == 1'b0 || (tw >> 13) != (va >> 13)) begin
            e_exc = (tb == 0) ? 3'd1 : 3'd2;
        end else begin
            x = sup ? fw[7] : fw[6];
            r = sup ? fw[8] : fw[6];
            w = sup ? fw[9] : fw[7];
            if (tb == 0) ok = x;
            else if (acc == ST) ok = w;
            else ok = r;
            if (!ok) begin
                e_exc = (tb == 0) ? 3'd3 : 3'd4;
            end else begin
                e_hit   = 1;
                e_paddr = (fw & 32'hFFFF_E000) | (va & 32'h0000_1FFF);
                e_perm  = (tb == 0) ? 3'b100 : {1'b0, w, r};
            end
        end
        if (e_exc != 0) e_fault = va;
    endtask

    task automatic step(input bit rv, input logic [31:0] va, input logic [1:0] acc,
                        input bit sup, input bit we, input bit wsel, input logic [5:0] widx,
                        input bit wtr, input logic [31:0] wval, input string tag);
        @(negedge clk);
        compare();
        req_valid = rv; req_vaddr = va; req_acc = acc; req_super = sup;
        wr_en = we; wr_sel_data = wsel; wr_idx = widx; wr_word_tr = wtr; wr_value = wval;
        predict(rv, va, acc, sup);
        e_tag = tag;
        if (we) mdl[wsel][widx][wtr] = wval;
    endtask

    task automatic req(input logic [31:0] va, input logic [1:0] acc, input bit sup,
                       input string tag);
        step(1, va, acc, sup, 0, 0, '0, 0, '0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, LD, 0, 0, 0, '0, 0, '0, tag);
    endtask

    // load a slot: tag word (with valid bit) then frame word (rights at bit 6)
    task automatic map(input bit tbl, input logic [31:0] va, input logic [31:0] pa,
                       input logic [3:0] rights, input bit vld, input string tag);
        logic [5:0] s;
        s = 6'((va >> 13) & 32'h3F);
        step(0, '0, LD, 0, 1, tbl, s, 0, (va & 32'hFFFF_E000) | 32'(vld), tag);
        step(0, '0, LD, 0, 1, tbl, s, 1, (pa & 32'hFFFF_E000) | (32'(rights) << 6), tag);
    endtask

    initial begin
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 64; s++) begin
                mdl[t][s][0] = '0;
                mdl[t][s][1] = '0;
            end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, then everything misses
        idle("R1");
        req(32'h0001_4000, FE, 0, "R1");
        req(32'h0001_4000, LD, 1, "R1");
        idle("R1");

        // R6: instruction slot with user execute only
        map(0, 32'h0004_6000, 32'h0ABC_E000, 4'b0001, 1, "R4");
        req(32'h0004_6123, FE, 0, "R6");
        req(32'h0004_7FFF, FE, 0, "R5");
        req(32'h0004_6010, FE, 1, "R6");
        // R12: same address through the data table misses
        req(32'h0004_6010, LD, 0, "R12");
        req(32'h0004_6010, ST, 1, "R12");

        // R4: write racing a read sees old contents, next cycle sees new
        step(0, '0, LD, 0, 1, 1, 6'((32'h1234_5678 >> 13) & 32'h3F), 1,
             32'h7654_2000 | (32'b1101 << 6), "R4");
        step(1, 32'h1234_5678, LD, 0, 1, 1, 6'((32'h1234_5678 >> 13) & 32'h3F), 0,
             32'h1234_4001, "R4");
        req(32'h1234_5678, LD, 0, "R4");

        // R7: user read only, supervisor read and write
        req(32'h1234_5678, ST, 0, "R7");
        req(32'h1234_5000, ST, 1, "R7");
        req(32'h1234_5ABC, LD, 1, "R7");
        req(32'h1234_5ABC, LD2, 0, "R6");
        // R10: hits leave the fault address alone
        req(32'h1234_5004, LD, 0, "R10");
        idle("R10");

        // R3: alias on the same slot with another tag misses
        req(32'h1234_5678 + (32'd64 << 13), LD, 0, "R3");
        req(32'h9234_5678, LD, 1, "R3");
        // R3: clearing valid makes the slot miss
        step(0, '0, LD, 0, 1, 1, 6'((32'h1234_5678 >> 13) & 32'h3F), 0, 32'h1234_4000, "R3");
        req(32'h1234_5678, LD, 1, "R3");

        // R7: write right without read right
        map(1, 32'h0080_2000, 32'h0F00_0000, 4'b0010, 1, "R7");
        req(32'h0080_2020, LD, 0, "R7");
        req(32'h0080_2020, ST, 0, "R7");
        req(32'h0080_2020, LD, 1, "R7");

        // R8: bypass window edges and user mode
        req(32'h0000_1FFC, FE, 1, "R8");
        req(32'h0000_0000, ST, 1, "R8");
        req(32'h0000_2000, LD, 1, "R8");
        req(32'h0000_0100, LD, 0, "R8");
        req(32'h0000_0100, FE, 0, "R8");

        // R9/R11: several slots, back-to-back mixed requests
        for (int k = 0; k < 8; k++) begin
            map(k[0], 32'h0100_0000 + (32'(k) << 13), 32'h2000_0000 + (32'(k) << 14),
                4'(k * 5 + 3), 1, "R9");
        end
        for (int k = 0; k < 8; k++) begin
            req(32'h0100_0000 + (32'(k) << 13) + 32'(k * 97), k[0] ? ST : FE, k[1], "R11");
            req(32'h0100_0000 + (32'(k) << 13) + 32'h40, k[0] ? LD : FE, !k[1], "R9");
        end
        idle("R2");
        idle("R2");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule